// File: doc/BRIEF.md
# Tree-structured 16:1 serializer

This block turns a stream of 16-bit parallel words into a single serial bit stream. The bit rate is sixteen times the word rate. Serialization is done by a binary tree of 2:1 multiplexer registers with four levels: eight muxes, then four, then two, then one. Each level updates twice as often as the level before it. In silicon each level would run on its own divide-by-two clock, and the last level would use both phases of the fastest clock. Here the fastest clock is modelled as a single bit-rate clock. The divided clocks become a free-running 4-bit phase counter, whose bits act as per-level load enables and mux selects. Everything sits in one clock domain.

Words arrive on a valid/ready interface.

- `in_ready` is high for one cycle in every sixteen, and it does not depend on `in_valid`.
- A word is taken on a rising edge where both `in_valid` and `in_ready` are high.
- A source that is not ready to send simply holds `in_valid` low. The block then fills that word slot with sixteen zero bits and raises no frame marker.
- A source that raises `in_valid` must hold it and `in_data` stable until `in_ready` is seen.

Bits leave least significant first. `frame_out` marks the cycle in which bit 0 of an accepted word is on the line.

Top module: `tree_serializer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ser_out`, `frame_out` and `in_ready` are all 0.
- R2: `in_ready` is high for exactly one cycle in every 16. After `rst` falls it is first high in cycle 15, counting the cycle that directly follows the release as cycle 0.
- R3: A word is taken only on a rising edge where `in_valid` and `in_ready` are both 1. At any other edge, `in_data` has no effect on the serial stream.
- R4: Bit i (0 = least significant) of an accepted word is on `ser_out` during the cycle that begins 15+i rising edges after the accepting edge. The 16 bits are therefore sent in the order 0, 1, …, 15.
- R5: `frame_out` is 1 exactly in the cycle that carries bit 0 of an accepted word, and that cycle is always one in which `in_ready` is 1.
- R6: A slot whose `in_ready` cycle sees `in_valid` = 0 produces 16 cycles of `ser_out` = 0 and no `frame_out` pulse.
- R7: Words accepted in consecutive slots form a gapless stream. Their `frame_out` pulses are exactly 16 cycles apart, and a PRBS-7 sequence (x^7 + x^6 + 1) split into words continues bit by bit on `ser_out`.
- R8: `in_ready` follows the same schedule whatever `in_valid` does.
- R9: Each tree level k (k = 1 to 4) updates its registers only once every 2^(4-k) cycles and holds them in between. Level 4 updates every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source has a word on `in_data` |
| in_ready | output | 1 | Word slot open this cycle (one cycle in 16) |
| in_data | input | 16 | Parallel word, bit 0 sent first |
| ser_out | output | 1 | Serial data bit |
| frame_out | output | 1 | High while bit 0 of an accepted word is on `ser_out` |

## Verification
The assertions check the following on every cycle:

- each tree level holds its registers between its load enables;
- the input register changes only at a word slot;
- an empty slot leaves a zero word;
- `in_ready` is a one-cycle pulse, and the phase counter wraps to zero;
- `frame_out` only coincides with an open slot;
- the outputs clear after reset.

Only the bench scenarios can show the following:

- the exact bit order and the 15-edge latency;
- the zero fill of empty slots with garbage on `in_data`;
- PRBS-7 continuity across back-to-back words;
- the walking-one and walking-zero sweeps;
- recovery after a reset in mid-word.

// File: rtl/tser_pkg.sv
package tser_pkg;

  // True when the lowest n bits of v are all ones (n = 0 gives true).
  function automatic logic low_ones(input logic [7:0] v, input int n);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i < n && !v[i]) r = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/tser_phase.sv
// Free-running phase counter standing in for the divide-by-two chain.
module tser_phase #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] phase,
  output logic          wrap
);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + CW'(1);
  end

  assign wrap = &phase;

  // R2: the slot phase is followed by phase zero
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (phase == '0));

endmodule

// File: rtl/tser_word_latch.sv
// Input word register, loaded once per slot.
module tser_word_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] word,
  output logic         word_ok
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word    <= '0;
      word_ok <= 1'b0;
    end else if (load) begin
      word    <= in_valid ? in_data : '0;
      word_ok <= in_valid;
    end
  end

  // R3: the word changes only at a slot
  a_r3_hold_off_slot: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word));

  // R6: an empty slot leaves an all-zero word
  a_r6_empty_is_zero: assert property (@(posedge clk) disable iff (rst)
    !word_ok |-> (word == '0));

endmodule

// File: rtl/tser_mux_level.sv
// One level of the 2:1 mux tree: N_IN streams merged into N_IN/2.
module tser_mux_level #(
  parameter int N_IN = 16,
  parameter int CW   = 4,
  parameter int LVL  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     phase,
  input  logic [N_IN-1:0]   d,
  output logic [N_IN/2-1:0] q
);

  localparam int N_OUT = N_IN / 2;
  localparam int LOWB  = CW - LVL;

  logic load;
  logic sel;

  assign load = tser_pkg::low_ones(8'(phase), LOWB);
  assign sel  = phase[LOWB];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      for (int j = 0; j < N_OUT; j++) begin
        q[j] <= sel ? d[j + N_OUT] : d[j];
      end
    end
  end

  // R9: level registers hold between their load enables
  a_r9_level_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

endmodule

// File: rtl/tree_serializer.sv
// W:1 serializer built from log2(W) cascaded 2:1 mux levels.
module tree_serializer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         ser_out,
  output logic         frame_out
);

  localparam int            CW       = $clog2(W);
  localparam logic [CW-1:0] PRE_LAST = CW'(W - 2);

  logic [CW-1:0] phase;
  logic          wrap;
  logic [W-1:0]  word;
  logic          word_ok;
  logic          frame_q;

  // Node storage: level k occupies nodes[(W>>k) +: (W>>k)], level 0 is the word.
  logic [2*W-1:1] nodes;

  tser_phase #(.CW(CW)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .wrap  (wrap)
  );

  tser_word_latch #(.W(W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .load     (wrap),
    .in_valid (in_valid),
    .in_data  (in_data),
    .word     (word),
    .word_ok  (word_ok)
  );

  assign nodes[W +: W] = word;

  for (genvar k = 1; k <= CW; k++) begin : g_level
    localparam int NI = W >> (k - 1);
    localparam int NO = W >> k;
    tser_mux_level #(.N_IN(NI), .CW(CW), .LVL(k)) u_lvl (
      .clk   (clk),
      .rst   (rst),
      .phase (phase),
      .d     (nodes[NI +: NI]),
      .q     (nodes[NO +: NO])
    );
  end

  // Bit 0 reaches the line in the cycle after phase W-2.
  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b0;
    else     frame_q <= (phase == PRE_LAST) && word_ok;
  end

  assign in_ready  = wrap;
  assign ser_out   = nodes[1];
  assign frame_out = frame_q;

  // R1: outputs are clear in the cycle after a reset edge
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!ser_out && !frame_out && !in_ready));

  // R2: the ready slot lasts a single cycle
  a_r2_ready_single: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  // R5: a frame marker only falls on a slot cycle
  a_r5_frame_in_slot: assert property (@(posedge clk) disable iff (rst)
    frame_out |-> in_ready);

endmodule

// File: tb/tree_serializer_test.sv
module tree_serializer_test;

  localparam int W          = 16;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready;
  logic         ser_out;
  logic         frame_out;

  tree_serializer #(.W(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .ser_out   (ser_out),
    .frame_out (frame_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;
  bit   exp_ser [0:DEPTH-1];
  bit   exp_frm [0:DEPTH-1];
  int   cyc;
  logic [W-1:0] sent [0:511];
  int   n_sent, n_rx;
  logic [W-1:0] rx_word;
  int   rx_bits;
  bit   rx_on;
  int   last_frame;
  bit   gapless;
  bit   prbs_mode;
  bit [6:0] hist;
  int   hist_n;
  logic [6:0] lfsr = 7'h5B;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [W-1:0] prbs_word();
    logic [W-1:0] w;
    logic nb;
    for (int i = 0; i < W; i++) begin
      nb   = lfsr[6] ^ lfsr[5];
      lfsr = {lfsr[5:0], nb};
      w[i] = nb;
    end
    return w;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) begin
      exp_ser[i] = 1'b0;
      exp_frm[i] = 1'b0;
    end
    cyc = 0; n_sent = 0; n_rx = 0; rx_bits = 0; rx_on = 1'b0;
    last_frame = -1; hist_n = 0; hist = '0;
  endtask

  task automatic reset_stream_checks();
    last_frame = -1; hist_n = 0;
  endtask

  // Compare outputs after edge number cyc and recover words.
  task automatic observe();
    bit exp_rdy;
    exp_rdy = ((cyc % W) == W - 1);
    check(in_ready === exp_rdy, "R2 R8 ready schedule", int'(in_ready), int'(exp_rdy));
    check(ser_out === exp_ser[cyc], "R4 R6 R9 serial bit", int'(ser_out), int'(exp_ser[cyc]));
    check(frame_out === exp_frm[cyc], "R5 frame marker", int'(frame_out), int'(exp_frm[cyc]));
    if (frame_out === 1'b1) begin
      if (gapless && last_frame >= 0)
        check(cyc - last_frame == W, "R7 frame spacing", cyc - last_frame, W);
      last_frame = cyc;
      rx_on   = 1'b1;
      rx_bits = 0;
    end
    if (rx_on) begin
      rx_word[rx_bits] = ser_out;
      rx_bits++;
      if (prbs_mode) begin
        if (hist_n >= 7)
          check(ser_out === (hist[6] ^ hist[5]), "R7 prbs continuity",
                int'(ser_out), int'(hist[6] ^ hist[5]));
        hist = {hist[5:0], ser_out};
        hist_n++;
      end
      if (rx_bits == W) begin
        check(rx_word === sent[n_rx], "R3 R4 recovered word", int'(rx_word), int'(sent[n_rx]));
        n_rx++;
        rx_on = 1'b0;
      end
    end
  endtask

  task automatic step(input bit v, input logic [W-1:0] d, output bit slot);
    in_valid = v;
    in_data  = d;
    slot     = (in_ready === 1'b1);
    if (slot && v) begin
      sent[n_sent] = d;
      n_sent++;
      if (cyc + 2*W < DEPTH) begin
        for (int i = 0; i < W; i++) exp_ser[cyc + W + i] = d[i];
        exp_frm[cyc + W] = 1'b1;
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    observe();
  endtask

  task automatic send_slot(input bit v, input logic [W-1:0] d);
    bit s;
    do step(v, d, s); while (!s);
  endtask

  task automatic flush();
    send_slot(1'b0, 16'hFFFF);
    send_slot(1'b0, 16'hA5A5);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ser_out === 1'b0 && frame_out === 1'b0 && in_ready === 1'b0,
          "R1 outputs during reset", {ser_out, frame_out, in_ready}, 0);
    clear_model();
    rst = 1'b0;
    check(ser_out === 1'b0 && frame_out === 1'b0 && in_ready === 1'b0,
          "R1 outputs after release", {ser_out, frame_out, in_ready}, 0);
    observe();
  endtask

  initial begin
    clear_model();
    gapless = 1'b0;
    prbs_mode = 1'b0;
    do_reset();

    // Back-to-back PRBS-7 words: gapless stream and exact latency (R7, R4)
    gapless = 1'b1;
    prbs_mode = 1'b1;
    for (int k = 0; k < 40; k++) send_slot(1'b1, prbs_word());
    flush();
    check(n_rx == n_sent, "R7 all prbs words recovered", n_rx, n_sent);
    gapless = 1'b0;
    prbs_mode = 1'b0;
    reset_stream_checks();

    // Empty slots with garbage on in_data (R3, R6)
    for (int k = 0; k < 24; k++) begin
      if (k % 3 == 1) send_slot(1'b0, 16'hFFFF ^ 16'(k));
      else            send_slot(1'b1, 16'(k * 16'h9E37) ^ 16'h5A5A);
    end
    flush();
    check(n_rx == n_sent, "R6 only valid words framed", n_rx, n_sent);

    // Walking one, walking zero, all-ones and all-zeros (R4)
    for (int i = 0; i < W; i++) send_slot(1'b1, 16'(1) << i);
    for (int i = 0; i < W; i++) send_slot(1'b1, ~(16'(1) << i));
    send_slot(1'b1, 16'hFFFF);
    send_slot(1'b1, 16'h0000);
    send_slot(1'b1, 16'hFFFF);
    flush();
    check(n_rx == n_sent, "R4 sweep words recovered", n_rx, n_sent);

    // Reset in the middle of a word, then resume (R1)
    send_slot(1'b1, 16'hC3A1);
    send_slot(1'b1, 16'h7E18);
    begin
      bit s;
      for (int i = 0; i < 5; i++) step(1'b0, 16'h0, s);
    end
    do_reset();
    send_slot(1'b1, 16'h1234);
    send_slot(1'b1, 16'hFEDC);
    flush();
    check(n_rx == n_sent, "R1 stream after mid reset", n_rx, n_sent);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule